// File: doc/BRIEF.md
# PCM Strobe-Framed Serial Port

This block is the slave end of a synchronous serial link that moves one 8-bit PCM sample per frame in each direction. A host device supplies a bit clock and an active-high strobe that spans exactly eight bit-clock cycles, once per 8 kHz frame. While the strobe is high, the block shifts a byte in from the serial input and shifts a byte out on the serial output. The same timeslot is used for transmit and receive. The output is not driven outside the slot. When the strobe ends, the block raises a delayed strobe for another eight bit periods, so that a second device on the same wires can take the following slot.

All serial inputs are treated as plain signals in one system clock domain. Each input passes through a two-stage synchroniser. The bit-clock edges are found by comparing consecutive synchronised samples. The received byte is presented in parallel at the end of its own slot, with a one-cycle valid pulse. The byte to send is taken from a parallel input when the slot opens. A quiet control replaces the outgoing byte with a fixed idle code.

Top module: `pcm_strobe_port`

## Requirements
- R1: After reset, serOutEn, rxValid and strobeDly are 0 and rxByte is 8'h00.
- R2: While strobe is high, serIn is sampled on each falling bit-clock edge, most significant bit first. After the eighth sample, rxByte holds the eight sampled bits before the strobe goes low.
- R3: rxValid is high for exactly one system clock per completed 8-bit slot. It is not raised at any other time, and rxByte keeps its value between slots.
- R4: serOut carries bit 7 of the latched byte from the start of the slot. It moves to the next lower bit on each later rising bit-clock edge inside the slot.
- R5: serOutEn is 1 while the strobe is high and 0 at all other times.
- R6: If quietEn is 1 when the strobe rises, the slot sends the QUIET_CODE parameter (default 8'hFF) in place of txByte.
- R7: strobeDly rises after the strobe falls and stays high for eight bit-clock periods. It falls on the eighth rising bit-clock edge after the strobe fall.
- R8: txByte and quietEn are latched when the strobe rises. Changes to txByte during a slot do not alter the bits sent in that slot.
- R9: A strobe that ends after fewer than eight falling bit-clock edges produces no rxValid pulse and leaves rxByte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock, sampled in the clk domain |
| strobe | input | 1 | Active-high timeslot strobe, eight bit clocks long |
| serIn | input | 1 | Serial receive data |
| txByte | input | 8 | Byte to transmit in the next slot |
| quietEn | input | 1 | Send the quiet code in place of txByte |
| serOut | output | 1 | Serial transmit data |
| serOutEn | output | 1 | Drive enable for serOut; low means high-impedance |
| rxByte | output | 8 | Last complete received byte |
| rxValid | output | 1 | One-cycle pulse when rxByte is updated |
| strobeDly | output | 1 | Delayed strobe for the next device in a chain |

## Verification
Directed frames come first. Alternating and complementary byte values show whether the bit order is reversed or a bit is dropped. All-zero and all-one bytes show a stuck serial line. After these come random bytes, random quiet settings and random slot lengths. A change to txByte in the middle of a slot shows whether the byte is latched at the start of the slot or read live. Short slots of one to seven bits show whether a partial byte is wrongly reported. The delayed strobe is checked in each bit period after every slot, which catches an off-by-one in its length.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic rxDone;
  } portCtl_t;
endpackage

// File: rtl/pcm_port_sync.sv
module pcm_port_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bclkS,
  input  logic     strbS,
  output portCtl_t ctl,
  output logic     serOutEn,
  output logic     strobeDly
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic bPrev, sPrev;
  logic riseE, fallE, sRise, sFall;
  logic [CW-1:0] bitCnt, dlyCnt;
  logic oeReg, dlyActive;

  assign riseE = bclkS & ~bPrev;
  assign fallE = ~bclkS & bPrev;
  assign sRise = strbS & ~sPrev;
  assign sFall = ~strbS & sPrev;

  always_comb begin
    ctl.loadTx   = sRise;
    ctl.shiftTx  = riseE & strbS & ~sRise;
    ctl.sampleRx = fallE & strbS;
    ctl.rxDone   = fallE & strbS & (bitCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bPrev     <= 1'b0;
      sPrev     <= 1'b0;
      bitCnt    <= '0;
      dlyCnt    <= '0;
      oeReg     <= 1'b0;
      dlyActive <= 1'b0;
    end else begin
      bPrev <= bclkS;
      sPrev <= strbS;
      oeReg <= strbS;
      if (sRise || sFall) bitCnt <= '0;
      else if (ctl.sampleRx) bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
      if (sFall) begin
        dlyActive <= 1'b1;
        dlyCnt    <= '0;
      end else if (dlyActive && riseE) begin
        if (dlyCnt == LAST) dlyActive <= 1'b0;
        else dlyCnt <= dlyCnt + 1'b1;
      end
    end
  end

  assign serOutEn  = oeReg;
  assign strobeDly = dlyActive;

  AST_SHIFT_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftTx |-> serOutEn); // R4
  AST_DLY_APART: assert property (@(posedge clk) disable iff (!rstN)
    strobeDly |-> !serOutEn); // R7
endmodule

// File: rtl/pcm_port_datapath.sv
module pcm_port_datapath
  import pcm_port_pkg::*;
#(
  parameter int              BITS       = 8,
  parameter logic [BITS-1:0] QUIET_CODE = '1
) (
  input  logic            clk,
  input  logic            rstN,
  input  portCtl_t        ctl,
  input  logic            dataS,
  input  logic [BITS-1:0] txByte,
  input  logic            quietEn,
  output logic            serOut,
  output logic [BITS-1:0] rxByte,
  output logic            rxValid
);
  logic [BITS-1:0] txShift, rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (ctl.loadTx) txShift <= quietEn ? QUIET_CODE : txByte;
      else if (ctl.shiftTx) txShift <= {txShift[BITS-2:0], 1'b0};
      if (ctl.sampleRx) rxShift <= {rxShift[BITS-2:0], dataS};
      if (ctl.rxDone) rxByte <= {rxShift[BITS-2:0], dataS};
      rxValid <= ctl.rxDone;
    end
  end

  assign serOut = txShift[BITS-1];

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R3
endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
  import pcm_port_pkg::*;
#(
  parameter int              BITS       = 8,
  parameter logic [BITS-1:0] QUIET_CODE = '1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bitClk,
  input  logic            strobe,
  input  logic            serIn,
  input  logic [BITS-1:0] txByte,
  input  logic            quietEn,
  output logic            serOut,
  output logic            serOutEn,
  output logic [BITS-1:0] rxByte,
  output logic            rxValid,
  output logic            strobeDly
);
  logic [2:0] rawIn, syncIn;
  portCtl_t   ctl;

  assign rawIn = {bitClk, strobe, serIn};

  pcm_port_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncIn)
  );

  pcm_port_ctrl #(.BITS(BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bclkS(syncIn[2]), .strbS(syncIn[1]),
    .ctl(ctl), .serOutEn(serOutEn), .strobeDly(strobeDly)
  );

  pcm_port_datapath #(.BITS(BITS), .QUIET_CODE(QUIET_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataS(syncIn[0]),
    .txByte(txByte), .quietEn(quietEn), .serOut(serOut),
    .rxByte(rxByte), .rxValid(rxValid)
  );

  AST_QUIET_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(serOutEn) && $past(quietEn)) |-> (serOut == QUIET_CODE[BITS-1])); // R6
  AST_VALID_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(serOutEn)); // R2
endmodule

// File: tb/pcm_strobe_port_tb.sv
module pcm_strobe_port_tb;
  localparam int HALF = 8;
  localparam logic [7:0] QUIET = 8'hFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0, strobe = 1'b0, serIn = 1'b0, quietEn = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic serOut, serOutEn, rxValid, strobeDly;
  logic [7:0] rxByte;

  int total = 0, bad = 0, vCount = 0;
  bit done = 0;
  logic [7:0] lastRx = 8'h00;

  always #2 clk = ~clk;

  pcm_strobe_port u_dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .strobe(strobe), .serIn(serIn),
    .txByte(txByte), .quietEn(quietEn), .serOut(serOut), .serOutEn(serOutEn),
    .rxByte(rxByte), .rxValid(rxValid), .strobeDly(strobeDly)
  );

  always @(negedge clk) if (rxValid) vCount++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expTx(input logic [7:0] tx, input bit quiet);
    return quiet ? QUIET : tx;
  endfunction

  task automatic halfBit(input logic clkLvl, input logic strb, input logic din);
    bitClk = clkLvl; strobe = strb; serIn = din;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic runFrame(input logic [7:0] tx, input logic [7:0] rx,
                          input bit quiet, input int nBits);
    logic [7:0] sent;
    for (int k = 0; k < 3; k++) begin
      halfBit(1'b1, 1'b0, 1'b0);
      check(serOutEn == 1'b0, "R5 idle oe", serOutEn, 0);
      halfBit(1'b0, 1'b0, 1'b0);
    end
    txByte = tx; quietEn = quiet; vCount = 0;
    sent = expTx(tx, quiet);
    for (int i = 0; i < nBits; i++) begin
      halfBit(1'b1, 1'b1, rx[7-i]);
      check(serOutEn == 1'b1, "R5 slot oe", serOutEn, 1);
      check(serOut == sent[7-i], quiet ? "R6 quiet bit" : "R4/R8 tx bit", serOut, sent[7-i]);
      if (i == 0) check(strobeDly == 1'b0, "R7 dly low in slot", strobeDly, 0);
      if (i == 3) txByte = 8'($urandom);
      halfBit(1'b0, 1'b1, rx[7-i]);
    end
    halfBit(1'b1, 1'b0, 1'b0);
    check(serOutEn == 1'b0, "R5 oe off", serOutEn, 0);
    if (nBits == 8) begin
      check(vCount == 1, "R3 valid count", vCount, 1);
      check(rxByte == rx, "R2 rx byte", rxByte, rx);
      lastRx = rx;
    end else begin
      check(vCount == 0, "R9 partial valid", vCount, 0);
      check(rxByte == lastRx, "R9 partial hold", rxByte, lastRx);
    end
    check(strobeDly == 1'b1, "R7 dly start", strobeDly, 1);
    halfBit(1'b0, 1'b0, 1'b0);
    for (int k = 1; k <= 8; k++) begin
      halfBit(1'b1, 1'b0, 1'b0);
      check(strobeDly == (k < 8), "R7 dly length", strobeDly, (k < 8));
      halfBit(1'b0, 1'b0, 1'b0);
    end
    check(vCount == ((nBits == 8) ? 1 : 0), "R3 no extra valid", vCount, (nBits == 8) ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(serOutEn == 1'b0, "R1 oe", serOutEn, 0);
    check(rxValid == 1'b0, "R1 valid", rxValid, 0);
    check(strobeDly == 1'b0, "R1 dly", strobeDly, 0);
    check(rxByte == 8'h00, "R1 rxByte", rxByte, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    runFrame(8'hA5, 8'h3C, 1'b0, 8);
    runFrame(8'h5A, 8'hC3, 1'b0, 8);
    runFrame(8'h00, 8'hFF, 1'b0, 8);
    runFrame(8'hFF, 8'h00, 1'b0, 8);
    runFrame(8'h12, 8'h81, 1'b1, 8);
    runFrame(8'h77, 8'h66, 1'b0, 5);
    runFrame(8'h99, 8'h11, 1'b1, 1);
    runFrame(8'h01, 8'h80, 1'b0, 8);
    for (int f = 0; f < 24; f++) begin
      int nb;
      nb = (($urandom % 4) == 0) ? 1 + int'($urandom % 7) : 8;
      runFrame(8'($urandom), 8'($urandom), (($urandom % 4) == 0), nb);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule